// File: doc/BRIEF.md
# A32 D32 Block-Transfer Bus Slave

This block is the slave end of an asynchronous backplane bus. It serves 32-bit single-word cycles and 32-bit block transfers into a small local word memory. The master drives an address, an address-modifier code and the long-word and write lines, then lowers the address strobe. While the address strobe stays low, the master runs one or more data beats. Each beat is a handshake on the two data strobes. The slave captures the address once, at the start of the cycle, and in a block transfer it steps to the next word after every acknowledged beat.

All bus inputs pass through a two-flop synchronizer, and the handshake runs in the local clock domain. The acknowledge has two outputs: a level (active low) and a separate output-enable, so the slave drives the shared line only while a beat is being answered. A configuration register at a fixed address holds an enable flag. Until that flag is set, the block answers no data-space cycle. The block answers with a bus error when a block transfer runs past the end of its 256-byte window.

Top module: `bltSlave`

## Requirements
- R1: After reset, ackOe, berr and dataOe are low, ackN is high, and the enable flag is clear, so a configuration read returns 0x00000000.
- R2: A configuration cycle uses modifier 0x2F at address 0x0007FFF8. It is acknowledged whether or not the block is enabled. A write loads the enable flag from data bit 4. A read returns the flag in bit 4 with all other bits zero. While the flag is clear, data cycles get no response.
- R3: After the master lowers both data strobes, the slave answers with ackOe high and ackN low. After both strobes return high, ackOe falls within three clock cycles, before the next beat can start.
- R4: ackOe and berr are never high together. berr stays low on every beat of a valid transfer.
- R5: The address is captured once, when the address strobe falls. With modifier 0x0F (block transfer), each acknowledged beat moves to the next 32-bit word.
- R6: With modifier 0x09 (single cycle), further beats under the same address strobe access the same word again.
- R7: Words written with 32-bit cycles read back unchanged. Words outside the written range keep their earlier contents.
- R8: Data cycles are decoded only for modifiers 0x0F and 0x09 with address bits [31:8] equal to 0x640000. Any other cycle never raises ackOe or berr.
- R9: A cycle with the long-word line high, or with address bits [1:0] not zero, gets no response. This covers a 16-bit block transfer.
- R10: In a block transfer, a beat that would cross the 256-byte window boundary is answered with berr instead of an acknowledge. Every later beat of the same cycle is answered the same way.
- R11: On a read beat, dataOe is high and the read word is on dataOut at least one cycle before ackOe rises. Both stay in place until the acknowledge is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 2 | Data strobes, active low; a beat needs both low |
| lwordN | input | 1 | Long-word line, low for 32-bit data |
| writeN | input | 1 | Low for a write cycle |
| amCode | input | 6 | Address-modifier code |
| addr | input | 32 | Byte address |
| dataIn | input | 32 | Write data from the master |
| dataOut | output | 32 | Read data to the master |
| dataOe | output | 1 | Enables the slave's data drivers |
| ackN | output | 1 | Acknowledge level, active low |
| ackOe | output | 1 | Acknowledge output-enable |
| berr | output | 1 | Bus-error indication |

## Verification
A table of single-beat cycles covers the following cases: configuration reads and writes, data writes made before and after enabling, and reads with a wrong modifier, a wrong window, a misaligned address and the long-word line high. Together these show how the block tells decode failures apart from the enable gate. Multi-beat cycles then compare a block write with a block read that starts one word lower. That read shows the per-beat stepping and that the words on either side are preserved. A single-cycle modifier with two beats is checked against the block modifier. A block read that starts two words below the window end separates the acknowledged beats from the bus-error beats. A 16-bit block transfer must get no response at all.

// File: rtl/bltPkg.sv
package bltPkg;
  localparam logic [5:0] AM_BLT32 = 6'h0F;
  localparam logic [5:0] AM_SGL32 = 6'h09;
  localparam logic [5:0] AM_CFG   = 6'h2F;

  // strobes from the control to the datapath
  typedef struct packed {
    logic latchAddr;
    logic memWrite;
    logic cfgWrite;
    logic loadRead;
    logic advance;
  } ctlStrobe_t;

  // qualifiers from the datapath to the control
  typedef struct packed {
    logic dataHit;
    logic cfgHit;
    logic crossed;
    logic isWrite;
  } dpStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ACCESS, ST_DRIVE, ST_ACK, ST_ERR, ST_SKIP
  } ctlState_t;
endpackage

// File: rtl/bltSync.sv
module bltSync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/bltDatapath.sv
module bltDatapath import bltPkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WORD_BITS = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6400_0000,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 32'h0007_FFF8,
  parameter int ENABLE_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [5:0]        amCode,
  input  logic              lwordS,
  input  logic              writeS,
  input  logic [DATA_W-1:0] dataIn,
  output dpStatus_t         status,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << WORD_BITS;
  localparam int WIN_LSB = WORD_BITS + 2;
  localparam logic [WORD_BITS-1:0] LAST_WORD = '1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [WORD_BITS-1:0] wordIdx;
  logic [5:0] amReg;
  logic winHit, alignOk, longReg, writeReg, cfgMatch, wrapped, enableReg;
  logic amOk;
  logic [DATA_W-1:0] cfgWord;

  // address phase: captured once per address strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx  <= '0;
      amReg    <= '0;
      winHit   <= 1'b0;
      alignOk  <= 1'b0;
      longReg  <= 1'b0;
      writeReg <= 1'b0;
      cfgMatch <= 1'b0;
      wrapped  <= 1'b0;
    end else if (ctl.latchAddr) begin
      wordIdx  <= addr[WIN_LSB-1:2];
      amReg    <= amCode;
      winHit   <= addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB];
      alignOk  <= addr[1:0] == 2'b00;
      longReg  <= !lwordS;
      writeReg <= !writeS;
      cfgMatch <= (amCode == AM_CFG) && (addr == CFG_ADDR);
      wrapped  <= 1'b0;
    end else if (ctl.advance && amReg == AM_BLT32) begin
      wordIdx <= wordIdx + 1'b1;
      if (wordIdx == LAST_WORD) wrapped <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ctl.memWrite) begin
      mem[wordIdx] <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableReg <= 1'b0;
    else if (ctl.cfgWrite) enableReg <= dataIn[ENABLE_BIT];
  end

  always_comb begin
    cfgWord = '0;
    cfgWord[ENABLE_BIT] = enableReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (ctl.loadRead) rdData <= cfgMatch ? cfgWord : mem[wordIdx];
  end

  assign amOk = (amReg == AM_BLT32) || (amReg == AM_SGL32);
  assign status.dataHit = enableReg && winHit && amOk && longReg && alignOk;
  assign status.cfgHit  = cfgMatch;
  assign status.crossed = wrapped;
  assign status.isWrite = writeReg;

  // R5: the word index moves only on an address capture or a beat advance
  assert_index_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.latchAddr && !ctl.advance) |=> $stable(wordIdx));
  // R6: single-cycle beats never step the index
  assert_single_no_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.latchAddr && ctl.advance && amReg == AM_SGL32) |=> $stable(wordIdx));
  // R2: memory is written only when the block is enabled
  assert_write_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWrite |-> enableReg);
endmodule

// File: rtl/bltControl.sv
module bltControl import bltPkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       asS,
  input  logic [1:0] dsS,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       ackOe,
  output logic       ackN,
  output logic       berr,
  output logic       dataOe
);
  ctlState_t state, nextState;
  logic asLow, dsAllLow, dsAllHigh, anyHit;

  assign asLow     = !asS;
  assign dsAllLow  = dsS == 2'b00;
  assign dsAllHigh = dsS == 2'b11;
  assign anyHit    = status.dataHit || status.cfgHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: if (asLow) begin
        ctl.latchAddr = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (!asLow) nextState = ST_IDLE;
        else if (dsAllLow) begin
          if (!anyHit) nextState = ST_SKIP;
          else if (status.dataHit && status.crossed) nextState = ST_ERR;
          else nextState = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        ctl.memWrite = status.isWrite && status.dataHit;
        ctl.cfgWrite = status.isWrite && status.cfgHit;
        ctl.loadRead = !status.isWrite;
        nextState = status.isWrite ? ST_ACK : ST_DRIVE;
      end
      ST_DRIVE: nextState = ST_ACK;
      ST_ACK: if (dsAllHigh) begin
        ctl.advance = 1'b1;
        nextState = asLow ? ST_WAIT : ST_IDLE;
      end
      ST_ERR, ST_SKIP: if (dsAllHigh) nextState = asLow ? ST_WAIT : ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign ackOe  = state == ST_ACK;
  assign ackN   = state != ST_ACK;
  assign berr   = state == ST_ERR;
  assign dataOe = (state == ST_DRIVE) || (state == ST_ACK && !status.isWrite);

  // R3: acknowledge released one cycle after the strobes are seen high
  assert_ack_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ackOe && dsAllHigh) |=> !ackOe);
  // R4: acknowledge and bus error are exclusive
  assert_ack_berr_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(ackOe && berr));
  // R10: bus error only after the window has been crossed
  assert_berr_crossed_R10: assert property (@(posedge clk) disable iff (!rstN)
    berr |-> (status.crossed && status.dataHit));
  // R8: acknowledge only for a decoded cycle
  assert_ack_needs_hit_R8: assert property (@(posedge clk) disable iff (!rstN)
    ackOe |-> anyHit);
  // R11: read data is driven a cycle before the acknowledge
  assert_data_before_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackOe) && !status.isWrite) |-> $past(dataOe));
endmodule

// File: rtl/bltSlave.sv
module bltSlave import bltPkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WORD_BITS = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6400_0000,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 32'h0007_FFF8,
  parameter int ENABLE_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic [1:0]        dsN,
  input  logic              lwordN,
  input  logic              writeN,
  input  logic [5:0]        amCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              ackN,
  output logic              ackOe,
  output logic              berr
);
  localparam int SYNC_W = 5;

  logic [SYNC_W-1:0] syncOut;
  logic asS, lwordS, writeS;
  logic [1:0] dsS;
  ctlStrobe_t ctl;
  dpStatus_t status;

  bltSync #(.WIDTH(SYNC_W), .STAGES(2), .RESET_VAL('1)) uSync (
    .clk(clk), .rstN(rstN),
    .din({asN, dsN, lwordN, writeN}),
    .dout(syncOut)
  );
  assign {asS, dsS, lwordS, writeS} = syncOut;

  bltControl uCtl (
    .clk(clk), .rstN(rstN), .asS(asS), .dsS(dsS), .status(status),
    .ctl(ctl), .ackOe(ackOe), .ackN(ackN), .berr(berr), .dataOe(dataOe)
  );

  bltDatapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS),
    .BASE_ADDR(BASE_ADDR), .CFG_ADDR(CFG_ADDR), .ENABLE_BIT(ENABLE_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr), .amCode(amCode),
    .lwordS(lwordS), .writeS(writeS), .dataIn(dataIn),
    .status(status), .rdData(dataOut)
  );
endmodule

// File: tb/tb_bltSlave.sv
module tb_bltSlave;
  localparam int HALF = 10; // 20 ns period, 50 MHz

  logic clk = 1'b0, rstN = 1'b0, asN = 1'b1, lwordN = 1'b1, writeN = 1'b1;
  logic [1:0] dsN = 2'b11;
  logic [5:0] amCode = '0;
  logic [31:0] addr = '0, dataIn = '0;
  logic [31:0] dataOut;
  logic dataOe, ackN, ackOe, berr;

  int checks = 0, errors = 0;
  int relErr = 0, berrOnAck = 0, oeErr = 0;

  always #HALF clk = ~clk;

  bltSlave dut (
    .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN), .lwordN(lwordN), .writeN(writeN),
    .amCode(amCode), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .ackN(ackN), .ackOe(ackOe), .berr(berr)
  );

  typedef struct packed {
    logic wr; logic lng; logic [5:0] am; logic [31:0] a;
    logic [31:0] d; logic [1:0] resp; logic [31:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 6'h2F, 32'h0007_FFF8, 32'h0, 2'd1, 32'h0},          // R1 enable clear
    '{1'b1, 1'b1, 6'h09, 32'h6400_0000, 32'h11, 2'd0, 32'h0},         // R2 disabled
    '{1'b1, 1'b1, 6'h2F, 32'h0007_FFF8, 32'h10, 2'd1, 32'h0},         // R2 enable
    '{1'b0, 1'b1, 6'h2F, 32'h0007_FFF8, 32'h0, 2'd1, 32'h10},         // R2 read flag
    '{1'b0, 1'b1, 6'h09, 32'h6400_0000, 32'h0, 2'd1, 32'h0},          // R2 ignored write
    '{1'b1, 1'b1, 6'h09, 32'h6400_0004, 32'hA5A5_0001, 2'd1, 32'h0},  // R7
    '{1'b0, 1'b1, 6'h0F, 32'h6400_0004, 32'h0, 2'd1, 32'hA5A5_0001},  // R7
    '{1'b0, 1'b1, 6'h3D, 32'h6400_0004, 32'h0, 2'd0, 32'h0},          // R8 modifier
    '{1'b0, 1'b1, 6'h09, 32'h6500_0004, 32'h0, 2'd0, 32'h0},          // R8 window
    '{1'b0, 1'b1, 6'h09, 32'h6400_0100, 32'h0, 2'd0, 32'h0},          // R8 window
    '{1'b0, 1'b1, 6'h09, 32'h6400_0006, 32'h0, 2'd0, 32'h0},          // R9 align
    '{1'b0, 1'b0, 6'h09, 32'h6400_0004, 32'h0, 2'd0, 32'h0},          // R9 short word
    '{1'b1, 1'b1, 6'h2F, 32'h0007_FFF8, 32'h0, 2'd1, 32'h0},          // R2 disable
    '{1'b0, 1'b1, 6'h09, 32'h6400_0004, 32'h0, 2'd0, 32'h0},          // R2 gated
    '{1'b1, 1'b1, 6'h2F, 32'h0007_FFF8, 32'h10, 2'd1, 32'h0}          // R2 re-enable
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic startCycle(input logic [5:0] am, input logic [31:0] a,
                            input logic lng, input logic wr);
    @(negedge clk);
    amCode = am; addr = a; lwordN = !lng; writeN = !wr;
    @(negedge clk);
    asN = 1'b0;
  endtask

  task automatic endCycle();
    @(negedge clk);
    asN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // resp: 0 none, 1 acknowledge, 2 bus error
  task automatic doBeat(input logic [31:0] wd, output int resp, output logic [31:0] rd);
    resp = 0; rd = '0;
    dataIn = wd;
    @(negedge clk);
    dsN = 2'b00;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (ackOe && !ackN) begin
        resp = 1; rd = dataOut;
        if (berr) berrOnAck++;
        if (writeN && !dataOe) oeErr++;
        break;
      end
      if (berr) begin resp = 2; break; end
    end
    dsN = 2'b11;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (resp == 1 && writeN && !ackOe && dataOut !== rd) oeErr++;
      if (!ackOe && !berr) break;
      if (i == 3) relErr++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %h expected %h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int resp;
    logic [31:0] rd;
    logic [31:0] blk [4];
    blk[0] = 32'h0011_2233; blk[1] = 32'h4455_6677;
    blk[2] = 32'h8899_AABB; blk[3] = 32'hCCDD_EEFF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 ackOe", {31'b0, ackOe}, 32'h0);
    check("R1 ackN", {31'b0, ackN}, 32'h1);
    check("R1 berr", {31'b0, berr}, 32'h0);
    check("R1 dataOe", {31'b0, dataOe}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      startCycle(VECS[v].am, VECS[v].a, VECS[v].lng, VECS[v].wr);
      doBeat(VECS[v].d, resp, rd);
      endCycle();
      check($sformatf("R2/R8/R9 vec%0d resp", v), resp, {30'b0, VECS[v].resp});
      if (VECS[v].resp == 2'd1 && !VECS[v].wr)
        check($sformatf("R7 vec%0d data", v), rd, VECS[v].exp);
    end

    // R5 R7: block write of four words, then block read one word lower
    startCycle(6'h0F, 32'h6400_0040, 1'b1, 1'b1);
    for (int b = 0; b < 4; b++) begin
      doBeat(blk[b], resp, rd);
      check("R5 block write ack", resp, 32'd1);
    end
    endCycle();
    startCycle(6'h0F, 32'h6400_003C, 1'b1, 1'b0);
    doBeat('0, resp, rd);
    check("R7 word below kept", rd, 32'h0);
    for (int b = 0; b < 4; b++) begin
      doBeat('0, resp, rd);
      check("R5 block read stepped", rd, blk[b]);
    end
    doBeat('0, resp, rd);
    check("R7 word above kept", rd, 32'h0);
    endCycle();

    // R6: single-cycle modifier re-reads the same word
    startCycle(6'h09, 32'h6400_0044, 1'b1, 1'b0);
    doBeat('0, resp, rd);
    check("R6 first beat", rd, blk[1]);
    doBeat('0, resp, rd);
    check("R6 second beat same word", rd, blk[1]);
    endCycle();

    // R10: two acknowledged beats, then bus error past the window end
    startCycle(6'h0F, 32'h6400_00F8, 1'b1, 1'b0);
    doBeat('0, resp, rd);
    check("R10 beat 62", resp, 32'd1);
    doBeat('0, resp, rd);
    check("R10 beat 63", resp, 32'd1);
    doBeat('0, resp, rd);
    check("R10 crossing berr", resp, 32'd2);
    doBeat('0, resp, rd);
    check("R10 later beat berr", resp, 32'd2);
    endCycle();

    // R9: 16-bit block transfer is not answered
    startCycle(6'h0F, 32'h6400_0040, 1'b0, 1'b0);
    doBeat('0, resp, rd);
    check("R9 short block beat 1", resp, 32'd0);
    doBeat('0, resp, rd);
    check("R9 short block beat 2", resp, 32'd0);
    endCycle();

    check("R3 ack released", relErr, 32'd0);
    check("R4 no berr with ack", berrOnAck, 32'd0);
    check("R11 data driven and held", oeErr, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule